// File: doc/BRIEF.md
# Plane-Wave IIR Transmit Beamfilter

This block steers a wideband transmit beam across a uniform line of antenna elements. It does this with one first-order two-dimensional recursive filter. The filter runs along two axes: the element index (space) and the sample index (time). It is built as a chain of identical stages, one per element. Only the head stage receives the temporal sample stream. Every later stage takes the current and previous values of its neighbour's input and output. Each stage's output is the drive signal for its own element.

The beam direction is set by three signed Q2.14 feedback coefficients: temporal `b01`, spatial `b10` and diagonal `b11`. Software computes them from the steering angle and writes them through a small write port. A two-state controller decides when a new set becomes active. In `CF_IDLE` the committed set is in use and nothing is pending. A valid write moves the controller to `CF_STAGED`. An accepted sample in `CF_STAGED` commits the staged set and returns to `CF_IDLE`. If a write arrives in that same cycle, the controller stays in `CF_STAGED`. Each coefficient set travels down the chain with its sample, so all elements filter a given sample with the same set. The chain is skewed: element m produces its result for a sample m cycles after element 0 does.

Top module: `pw_tx_beamfilter`

## Requirements
- R1: After reset, all element outputs are 0, `elem_valid` is all zero, and all three coefficients are 0. The first sample after reset therefore appears unchanged at element 0.
- R2: Element 0 computes y[n] = x[n] + x[n-1] - b01*y[n-1]. Its neighbour terms are zero (zero boundary).
- R3: Element m>0 has no input of its own. It computes y_m[n] = xm1[n] + xm1[n-1] - b01*y_m[n-1] - b10*y_{m-1}[n] - b11*y_{m-1}[n-1]. Here xm1 is element m-1's own input, which is the sample for m=1 and zero for m>1.
- R4: A sample accepted on a rising edge with `in_valid` high gives element m's result on the m-th rising edge after it. On that edge the element's `elem_valid[m]` is raised for one cycle.
- R5: Each stage computes the sum in Q.14. It adds 2^13, shifts right arithmetically by 14 (round half up), then saturates to [-32768, 32767].
- R6: While no sample reaches a stage, that stage's output and all of its history hold their values.
- R7: `coef_sel` encodes 0 = b01, 1 = b10, 2 = b11. Code 3 writes nothing and has no effect on any output.
- R8: A write takes effect from the first sample accepted after the write's cycle. A sample accepted in the same cycle as a write uses the set in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A new temporal sample is present |
| in_sample | input | 16 | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 2 | Coefficient select (R7 encoding) |
| coef_data | input | 16 | Signed Q2.14 coefficient value |
| elem_valid | output | 8 | Per-element new-result flag |
| elem_y | output | 128 | Element outputs, element m in bits [16m+15:16m] |

## Verification
A sample entering the chain and a coefficient write can fall in the same cycle. This decides which set that sample and the later ones use. The bench drives both on one edge, once with a staged set already pending and once without. It then compares every element's result stream against an integer model of the recursion that applies the commit rule of R8. Saturation and half-up rounding are provoked with coefficients chosen to produce exact halves and unbounded growth.

// File: rtl/bf_pkg.sv
package bf_pkg;
    parameter int BF_COEF_W    = 16;
    parameter int BF_COEF_FRAC = 14;

    typedef struct packed {
        logic signed [BF_COEF_W-1:0] b01;
        logic signed [BF_COEF_W-1:0] b10;
        logic signed [BF_COEF_W-1:0] b11;
    } bf_coef_t;

    typedef enum logic [1:0] {
        SEL_B01  = 2'd0,
        SEL_B10  = 2'd1,
        SEL_B11  = 2'd2,
        SEL_NONE = 2'd3
    } bf_sel_e;

    typedef enum logic {
        CF_IDLE   = 1'b0,
        CF_STAGED = 1'b1
    } bf_cstate_e;
endpackage

// File: rtl/bf_coef_ctrl.sv
module bf_coef_ctrl
    import bf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 samp_v,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [BF_COEF_W-1:0] wr_data,
    output bf_coef_t             act_coef
);
    bf_cstate_e state, state_nxt;
    bf_coef_t   staged, committed;
    logic       wr_ok;

    assign wr_ok = wr_en && (bf_sel_e'(wr_sel) != SEL_NONE);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CF_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            CF_IDLE:   if (wr_ok) state_nxt = CF_STAGED;
            CF_STAGED: if (samp_v && !wr_ok) state_nxt = CF_IDLE;
            default:   state_nxt = CF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged    <= '0;
            committed <= '0;
        end else begin
            if (samp_v && state == CF_STAGED) committed <= staged;
            if (wr_ok) begin
                unique case (bf_sel_e'(wr_sel))
                    SEL_B01: staged.b01 <= $signed(wr_data);
                    SEL_B10: staged.b10 <= $signed(wr_data);
                    SEL_B11: staged.b11 <= $signed(wr_data);
                    default: staged     <= staged;
                endcase
            end
        end
    end

    always_comb begin
        unique case (state)
            CF_STAGED: act_coef = staged;
            default:   act_coef = committed;
        endcase
    end

    // R8
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_v && state == CF_STAGED) |=> (committed == $past(staged)));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CF_IDLE && !(wr_en && wr_sel != 2'd3)) |=> (state == CF_IDLE));
    // R8
    no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!samp_v) |=> $stable(committed));
endmodule

// File: rtl/bf_stage.sv
module bf_stage
    import bf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v_in,
    input  logic signed [DATA_W-1:0] x_in,
    input  logic signed [DATA_W-1:0] nx_in,
    input  logic signed [DATA_W-1:0] ny_in,
    input  bf_coef_t                 coef_in,
    output logic                     v_out,
    output logic signed [DATA_W-1:0] x_out,
    output logic signed [DATA_W-1:0] y_out,
    output bf_coef_t                 coef_out
);
    localparam int SUM_W  = DATA_W + 2;
    localparam int PROD_W = DATA_W + BF_COEF_W;
    localparam int ACC_W  = PROD_W + 3;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (BF_COEF_FRAC - 1);
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

    logic signed [DATA_W-1:0] x_prev, nb_x_prev, nb_y_prev;
    logic signed [SUM_W-1:0]  ff_sum;
    logic signed [PROD_W-1:0] p01, p10, p11;
    logic signed [ACC_W-1:0]  acc, rnd;
    logic signed [DATA_W-1:0] y_nxt;

    assign ff_sum = SUM_W'(x_in) + SUM_W'(x_prev) + SUM_W'(nx_in) + SUM_W'(nb_x_prev);
    assign p01 = $signed(coef_in.b01) * y_out;
    assign p10 = $signed(coef_in.b10) * ny_in;
    assign p11 = $signed(coef_in.b11) * nb_y_prev;
    assign acc = (ACC_W'(ff_sum) <<< BF_COEF_FRAC) - ACC_W'(p01) - ACC_W'(p10) - ACC_W'(p11);
    assign rnd = (acc + HALF) >>> BF_COEF_FRAC;

    always_comb begin
        if (rnd > MAXV)      y_nxt = MAXV[DATA_W-1:0];
        else if (rnd < MINV) y_nxt = MINV[DATA_W-1:0];
        else                 y_nxt = rnd[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_out     <= 1'b0;
            x_out     <= '0;
            y_out     <= '0;
            x_prev    <= '0;
            nb_x_prev <= '0;
            nb_y_prev <= '0;
            coef_out  <= '0;
        end else begin
            v_out <= v_in;
            if (v_in) begin
                x_out     <= x_in;
                y_out     <= y_nxt;
                x_prev    <= x_in;
                nb_x_prev <= nx_in;
                nb_y_prev <= ny_in;
                coef_out  <= coef_in;
            end
        end
    end

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!v_in) |=> ($stable(y_out) && $stable(nb_y_prev) && $stable(x_prev)));
    // R5
    zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && x_in == 0 && nx_in == 0 && ny_in == 0 && x_prev == 0 &&
         nb_x_prev == 0 && nb_y_prev == 0 && y_out == 0) |=> (y_out == 0));
    // R4
    valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_in |=> v_out);
endmodule

// File: rtl/pw_tx_beamfilter.sv
module pw_tx_beamfilter
    import bf_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    parameter int DATA_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [DATA_W-1:0]   in_sample,
    input  logic                       coef_we,
    input  logic [1:0]                 coef_sel,
    input  logic [BF_COEF_W-1:0]       coef_data,
    output logic [NUM_ELEM-1:0]        elem_valid,
    output logic [NUM_ELEM*DATA_W-1:0] elem_y
);
    bf_coef_t                 act;
    logic [NUM_ELEM-1:0]      v_o;
    logic signed [DATA_W-1:0] x_o [NUM_ELEM];
    logic signed [DATA_W-1:0] y_o [NUM_ELEM];
    bf_coef_t                 c_o [NUM_ELEM];

    bf_coef_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp_v   (in_valid),
        .wr_en    (coef_we),
        .wr_sel   (coef_sel),
        .wr_data  (coef_data),
        .act_coef (act)
    );

    for (genvar m = 0; m < NUM_ELEM; m++) begin : g_el
        logic                     v_i;
        logic signed [DATA_W-1:0] x_i, nx_i, ny_i;
        bf_coef_t                 c_i;
        if (m == 0) begin : g_head
            assign v_i  = in_valid;
            assign x_i  = in_sample;
            assign nx_i = '0;
            assign ny_i = '0;
            assign c_i  = act;
        end else begin : g_body
            assign v_i  = v_o[m-1];
            assign x_i  = '0;
            assign nx_i = x_o[m-1];
            assign ny_i = y_o[m-1];
            assign c_i  = c_o[m-1];
        end
        bf_stage #(.DATA_W(DATA_W)) i_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .v_in     (v_i),
            .x_in     (x_i),
            .nx_in    (nx_i),
            .ny_in    (ny_i),
            .coef_in  (c_i),
            .v_out    (v_o[m]),
            .x_out    (x_o[m]),
            .y_out    (y_o[m]),
            .coef_out (c_o[m])
        );
        assign elem_y[m*DATA_W +: DATA_W] = y_o[m];
        if (m < NUM_ELEM - 1) begin : g_chk
            // R4
            chain_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
                elem_valid[m] |=> elem_valid[m+1]);
        end
    end

    assign elem_valid = v_o;
endmodule

// File: tb/test_pw_tx_beamfilter.sv
`timescale 1ns/1ps
module test_pw_tx_beamfilter;
    localparam int NE = 8;
    localparam int DW = 16;
    localparam int QD = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_sample = '0;
    logic coef_we = 1'b0;
    logic [1:0] coef_sel = '0;
    logic [15:0] coef_data = '0;
    logic [NE-1:0] elem_valid;
    logic [NE*DW-1:0] elem_y;

    always #2.5 clk = ~clk;

    pw_tx_beamfilter #(.NUM_ELEM(NE), .DATA_W(DW)) i_pw_tx_beamfilter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .coef_we(coef_we), .coef_sel(coef_sel), .coef_data(coef_data),
        .elem_valid(elem_valid), .elem_y(elem_y)
    );

    int total = 0;
    int bad = 0;
    string cur_req = "R1";
    bit mon_on = 0;

    // reference model state
    longint mc[3], ms[3];
    bit     pend = 0;
    longint xp[NE], nxp[NE], nyp[NE], yp[NE];
    int     expq[NE][QD];
    int     wp[NE], rp[NE];
    int     last_y[NE];

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
        end
    endtask

    function automatic int yel(input int m);
        return int'($signed(elem_y[m*DW +: DW]));
    endfunction

    task automatic model_sample(input longint x);
        longint used[3];
        longint xc[NE], yc[NE];
        for (int k = 0; k < 3; k++) used[k] = pend ? ms[k] : mc[k];
        if (pend) begin
            for (int k = 0; k < 3; k++) mc[k] = ms[k];
            pend = 0;
        end
        for (int m = 0; m < NE; m++) begin
            longint xm, nx, ny, s, acc, r;
            xm  = (m == 0) ? x : 0;
            nx  = (m == 0) ? 0 : xc[m-1];
            ny  = (m == 0) ? 0 : yc[m-1];
            s   = xm + xp[m] + nx + nxp[m];
            acc = s * 16384 - used[0] * yp[m] - used[1] * ny - used[2] * nyp[m];
            r   = (acc + 8192) >>> 14;
            if (r > 32767) r = 32767;
            if (r < -32768) r = -32768;
            xp[m] = xm; nxp[m] = nx; nyp[m] = ny; yp[m] = r;
            xc[m] = xm; yc[m] = r;
            expq[m][wp[m] % QD] = int'(r);
            wp[m]++;
        end
    endtask

    task automatic step(input bit v, input int x, input bit we, input int sel, input int d);
        @(negedge clk);
        in_valid  = v;
        in_sample = DW'(x);
        coef_we   = we;
        coef_sel  = 2'(sel);
        coef_data = 16'(d);
        if (v) model_sample(longint'(x));
        if (we && sel != 3) begin
            ms[sel] = longint'(d);
            pend = 1;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            for (int m = 0; m < NE; m++) begin
                int yv;
                yv = yel(m);
                if (elem_valid[m]) begin
                    if (rp[m] >= wp[m]) chk(0, {cur_req, " unexpected valid"}, m, -1);
                    else begin
                        chk(yv == expq[m][rp[m] % QD], cur_req, yv, expq[m][rp[m] % QD]);
                        rp[m]++;
                    end
                end else begin
                    chk(yv == last_y[m], "R6 hold", yv, last_y[m]);
                end
                last_y[m] = yv;
            end
        end
    end

    task automatic t_reset();
        cur_req = "R1";
        chk(elem_valid == '0, "R1 valid after reset", elem_valid, 0);
        for (int m = 0; m < NE; m++) chk(yel(m) == 0, "R1 output after reset", yel(m), 0);
        step(1, 500, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk(yel(0) == 500, "R1 zero coefficients pass sample", yel(0), 500);
        idle(NE + 2);
    endtask

    task automatic t_latency();
        cur_req = "R4";
        step(1, 77, 0, 0, 0);
        for (int j = 0; j < NE; j++) begin
            step(0, 0, 0, 0, 0);
            chk(elem_valid == NE'(1) << j, "R4 skew", elem_valid, NE'(1) << j);
        end
        idle(3);
    endtask

    task automatic t_impulse();
        cur_req = "R2/R3 impulse";
        step(0, 0, 1, 0, 10125);
        step(0, 0, 1, 1, 3868);
        step(0, 0, 1, 2, -2391);
        step(1, 1000, 0, 0, 0);
        for (int i = 0; i < 23; i++) step(1, 0, 0, 0, 0);
        idle(NE + 2);
    endtask

    task automatic t_round();
        cur_req = "R5 rounding";
        step(0, 0, 1, 0, 8192);
        step(0, 0, 1, 1, 0);
        step(0, 0, 1, 2, 0);
        for (int i = 0; i < 30; i++) step(1, 0, 0, 0, 0);
        idle(NE + 2);
        step(1, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk(yel(0) == 1, "R5 first", yel(0), 1);
        step(1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk(yel(0) == 1, "R5 half rounds up", yel(0), 1);
        step(1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk(yel(0) == 0, "R5 minus half rounds to zero", yel(0), 0);
        idle(NE + 2);
    endtask

    task automatic t_sine();
        cur_req = "R2/R3/R6 sine";
        step(0, 0, 1, 0, 10125);
        step(0, 0, 1, 1, 3868);
        step(0, 0, 1, 2, -2391);
        for (int n = 0; n < 60; n++) begin
            int s;
            s = $rtoi(8000.0 * $sin(2.0 * 3.14159265358979 * n / 16.0));
            step(1, s, 0, 0, 0);
            if (n % 5 == 4) idle(2);
        end
        idle(NE + 2);
    endtask

    task automatic t_coef();
        cur_req = "R7/R8 coefficient timing";
        step(0, 0, 1, 3, 16000);
        for (int i = 0; i < 4; i++) step(1, 2000 - i * 300, 0, 0, 0);
        step(1, 1500, 1, 0, -6000);
        step(1, 900, 0, 0, 0);
        step(1, 700, 1, 1, 9000);
        step(1, 300, 1, 2, 4000);
        step(1, -400, 0, 0, 0);
        step(1, -900, 1, 3, -16000);
        for (int i = 0; i < 8; i++) step(1, 100 * i, 0, 0, 0);
        idle(NE + 2);
    endtask

    task automatic t_sat();
        cur_req = "R5 saturation";
        step(0, 0, 1, 0, -16384);
        step(0, 0, 1, 1, 0);
        step(0, 0, 1, 2, 0);
        for (int i = 0; i < 4; i++) step(1, 30000, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk(yel(0) == 32767, "R5 positive clip", yel(0), 32767);
        for (int i = 0; i < 6; i++) step(1, -30000, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk(yel(0) == -32768, "R5 negative clip", yel(0), -32768);
        idle(NE + 2);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++) begin mc[k] = 0; ms[k] = 0; end
        for (int m = 0; m < NE; m++) begin
            xp[m] = 0; nxp[m] = 0; nyp[m] = 0; yp[m] = 0;
            wp[m] = 0; rp[m] = 0; last_y[m] = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1;
        t_reset();
        t_latency();
        t_impulse();
        t_round();
        t_sine();
        t_coef();
        t_sat();
        for (int m = 0; m < NE; m++)
            chk(rp[m] == wp[m], "R4 all results delivered", rp[m], wp[m]);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule